// File: doc/BRIEF.md
# System Clock Source and Idle Controller

This block produces the system clock of a small microcontroller and controls its low-power states. Software programs one 8-bit configuration register over a simple write port, and the block drives the register contents back on a read port at all times. The register selects the fast source and the slow source. Each source is either an internal RC oscillator or an external crystal. The register also sets a clock code that picks the undivided fast clock, a power-of-two division of the fast clock, or the slow clock. The block switches between clocks without glitches. Each change passes through two-stage handover cells, and each cell holds the old clock low until the new clock has been captured.

When the CPU raises its halt request, the block leaves normal run. Two idle-enable bits decide which state it enters. The block gates the CPU clock off in every halted state. It drives one enable output per oscillator, so that power control outside the block can keep or stop each source. A wake pulse returns the block to run. The CPU clock then reopens on a low phase of the system clock.

Top module: `sysclk_idle_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the mode output is RUN (0), and only the internal fast and internal slow oscillator enables are high.
- R2: A write stores bits 7..5 and 3..0 and is visible on the read port one clock later; bit 4 always reads 0.
- R3: The clock code in bits 7..5 sets the system clock: code 0 is the fast clock, codes 1 to 6 divide the fast clock by 2, 4, 8, 16, 32 and 64, and code 7 is the slow clock.
- R4: Bit 3 picks the fast source (0 internal RC, 1 external crystal). In run, only the enable of the picked fast oscillator is high.
- R5: Bit 2 picks the slow source (0 internal RC, 1 external crystal). In run, only the enable of the picked slow oscillator is high.
- R6: A halt in run with bit 1 and bit 0 both set enters IDLE1 (mode 1). Both picked oscillator enables stay high, the CPU clock stops, and the system clock keeps running.
- R7: A halt in run with bit 1 set and bit 0 clear enters IDLE2 (mode 2). Only the picked fast oscillator enable stays high, and the CPU clock stops.
- R8: A halt in run with bit 1 clear enters STOP (mode 3). All four oscillator enables are low, and the CPU clock stops.
- R9: A wake pulse in a halted state returns the mode to RUN on the next clock. The CPU clock shows a rising edge within two system clock periods and runs at the system clock rate.
- R10: During any source or divider change, every high and low phase of the system and CPU clocks lasts at least half a period of the fastest source clock.
- R11: A halt while halted is ignored, and a wake in run is ignored. When halt and wake arrive together, wake wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control and bus clock |
| rst | input | 1 | Active-high reset, synchronous for control state |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register contents, bit 4 forced to 0 |
| halt | input | 1 | Halt request from the CPU, one-cycle pulse |
| wake | input | 1 | Wake-up request, one-cycle pulse |
| hirc_clk | input | 1 | Internal fast RC oscillator clock |
| hxt_clk | input | 1 | External fast crystal clock |
| lirc_clk | input | 1 | Internal slow RC oscillator clock |
| lxt_clk | input | 1 | External slow crystal clock |
| hirc_en | output | 1 | Enable for the internal fast RC oscillator |
| hxt_en | output | 1 | Enable for the external fast crystal |
| lirc_en | output | 1 | Enable for the internal slow RC oscillator |
| lxt_en | output | 1 | Enable for the external slow crystal |
| sys_clk | output | 1 | Selected system clock for peripherals |
| cpu_clk | output | 1 | Gated CPU clock |
| mode | output | 2 | Power state: RUN 0, IDLE1 1, IDLE2 2, STOP 3 |

## Verification
The bench builds the block with the default divider depth of six stages. At that depth every clock code from 0 to 7 maps to a real clock, so the whole code space can be measured, including the divide-by-64 limit. The source clocks are given distinct periods of 10, 14, 100 and 160 ns. A wrong source, a wrong divisor or a swapped slow/fast choice therefore shows up as a different measured period. Edge monitors record the shortest high and low phase of both output clocks across every switch made in the vector walk.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int REG_W  = 8;
    localparam int CSEL_W = 3;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE1 = 2'd1,
        MODE_IDLE2 = 2'd2,
        MODE_STOP  = 2'd3
    } pwr_mode_e;

    typedef struct packed {
        logic [CSEL_W-1:0] csel;
        logic              hi_xt;
        logic              lo_xt;
        logic              hi_idle;
        logic              lo_idle;
    } clk_cfg_t;

    typedef struct packed {
        logic hirc;
        logic hxt;
        logic lirc;
        logic lxt;
    } osc_en_t;

    function automatic clk_cfg_t cfg_from_bus(input logic [REG_W-1:0] d);
        clk_cfg_t c;
        c.csel    = d[7:5];
        c.hi_xt   = d[3];
        c.lo_xt   = d[2];
        c.hi_idle = d[1];
        c.lo_idle = d[0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_bus(input clk_cfg_t c);
        return {c.csel, 1'b0, c.hi_xt, c.lo_xt, c.hi_idle, c.lo_idle};
    endfunction

    // State entered from run when the CPU halts.
    function automatic pwr_mode_e halt_target(input clk_cfg_t c);
        if (!c.hi_idle)     return MODE_STOP;
        else if (c.lo_idle) return MODE_IDLE1;
        else                return MODE_IDLE2;
    endfunction

    // Oscillator enables for a given state and source choice.
    function automatic osc_en_t osc_plan(input pwr_mode_e m, input logic hi_xt,
                                         input logic lo_xt);
        osc_en_t e;
        logic    hi_on;
        logic    lo_on;
        hi_on  = (m != MODE_STOP);
        lo_on  = (m == MODE_RUN) || (m == MODE_IDLE1);
        e.hirc = hi_on & ~hi_xt;
        e.hxt  = hi_on &  hi_xt;
        e.lirc = lo_on & ~lo_xt;
        e.lxt  = lo_on &  lo_xt;
        return e;
    endfunction

endpackage

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
    import clkctl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [REG_W-1:0]         wr_data,
    input  logic                     halt,
    input  logic                     wake,
    output logic [REG_W-1:0]         rd_data,
    output logic [CSEL_W-1:0]        csel,
    output logic                     hi_xt,
    output logic                     lo_xt,
    output pwr_mode_e                mode,
    output osc_en_t                  osc_en
);

    clk_cfg_t  cfg_q;
    pwr_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '0;
        else if (wr_en) cfg_q <= cfg_from_bus(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst)                              mode_q <= MODE_RUN;
        else if (wake)                        mode_q <= MODE_RUN;
        else if (mode_q == MODE_RUN && halt)  mode_q <= halt_target(cfg_q);
    end

    always_comb begin
        rd_data = cfg_to_bus(cfg_q);
        csel    = cfg_q.csel;
        hi_xt   = cfg_q.hi_xt;
        lo_xt   = cfg_q.lo_xt;
        mode    = mode_q;
        osc_en  = osc_plan(mode_q, cfg_q.hi_xt, cfg_q.lo_xt);
    end

    p_wr_readback_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == {$past(wr_data[7:5]), 1'b0, $past(wr_data[3:0])});

    p_halt_idle1_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN && halt && !wake && cfg_q.hi_idle && cfg_q.lo_idle)
        |=> (mode_q == MODE_IDLE1));

    p_halt_idle2_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN && halt && !wake && cfg_q.hi_idle && !cfg_q.lo_idle)
        |=> (mode_q == MODE_IDLE2 && !osc_en.lirc && !osc_en.lxt));

    p_halt_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN && halt && !wake && !cfg_q.hi_idle)
        |=> (mode_q == MODE_STOP && osc_en == '0));

    p_wake_run_r9: assert property (@(posedge clk) disable iff (rst)
        wake |=> (mode_q == MODE_RUN));

    p_halted_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_RUN && !wake) |=> $stable(mode_q));

endmodule

// File: rtl/clk_gmux.sv
// Two-input clock switch: each side arms in its own clock domain
// (rising-edge capture, then falling-edge enable) only after the
// other side has fully released.
module clk_gmux (
    input  logic rst,
    input  logic clk_a,
    input  logic clk_b,
    input  logic sel,
    output logic clk_o
);

    logic a_s1, a_on, b_s1, b_on;

    always_ff @(posedge clk_a or posedge rst) begin
        if (rst) a_s1 <= 1'b0;
        else     a_s1 <= !sel && !b_s1 && !b_on;
    end

    always_ff @(negedge clk_a or posedge rst) begin
        if (rst) a_on <= 1'b0;
        else     a_on <= a_s1;
    end

    always_ff @(posedge clk_b or posedge rst) begin
        if (rst) b_s1 <= 1'b0;
        else     b_s1 <= sel && !a_s1 && !a_on;
    end

    always_ff @(negedge clk_b or posedge rst) begin
        if (rst) b_on <= 1'b0;
        else     b_on <= b_s1;
    end

    assign clk_o = (clk_a & a_on) | (clk_b & b_on);

    p_one_side_r10: assert property (@(posedge clk_a) disable iff (rst)
        !(a_on && b_on));

endmodule

// File: rtl/clk_pow2_div.sv
// Power-of-two divider. The requested ratio is synchronized and only
// adopted when the counter wraps, where every output tap is low.
module clk_pow2_div #(
    parameter int DIV_W = 6,
    parameter int SEL_W = 3
) (
    input  logic             rst,
    input  logic             clk_i,
    input  logic [SEL_W-1:0] csel,
    output logic             clk_o
);

    localparam logic [SEL_W-1:0] K_ONE = SEL_W'(1);

    logic [SEL_W-1:0] sel_s1, sel_s2, k_q, k_pick, k_n;
    logic [DIV_W-1:0] cnt_q, cnt_n;
    logic             div_q, div_n;

    always_ff @(posedge clk_i or posedge rst) begin
        if (rst) begin
            sel_s1 <= '0;
            sel_s2 <= '0;
        end else begin
            sel_s1 <= csel;
            sel_s2 <= sel_s1;
        end
    end

    always_comb begin
        if (sel_s2 != '0 && int'(sel_s2) <= DIV_W) k_pick = sel_s2;
        else                                         k_pick = K_ONE;
        cnt_n = cnt_q + 1'b1;
        k_n   = (cnt_q == '1) ? k_pick : k_q;
        div_n = 1'b0;
        for (int i = 0; i < DIV_W; i++) begin
            if (k_n == SEL_W'(i + 1)) div_n = cnt_n[i];
        end
    end

    always_ff @(posedge clk_i or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
            k_q   <= K_ONE;
            div_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            k_q   <= k_n;
            div_q <= div_n;
        end
    end

    assign clk_o = div_q;

    p_ratio_at_wrap_r3: assert property (@(posedge clk_i) disable iff (rst)
        (cnt_q != '1) |=> (k_q == $past(k_q)));

endmodule

// File: rtl/clk_gate_sync.sv
// CPU clock gate: enable captured on a rising edge, applied on a
// falling edge so the output only opens or closes in a low phase.
module clk_gate_sync (
    input  logic rst,
    input  logic clk_i,
    input  logic en,
    output logic clk_o
);

    logic g_s1, g_on;

    always_ff @(posedge clk_i or posedge rst) begin
        if (rst) g_s1 <= 1'b0;
        else     g_s1 <= en;
    end

    always_ff @(negedge clk_i or posedge rst) begin
        if (rst) g_on <= 1'b0;
        else     g_on <= g_s1;
    end

    assign clk_o = clk_i & g_on;

endmodule

// File: rtl/sysclk_idle_ctrl.sv
module sysclk_idle_ctrl
    import clkctl_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       halt,
    input  logic       wake,
    input  logic       hirc_clk,
    input  logic       hxt_clk,
    input  logic       lirc_clk,
    input  logic       lxt_clk,
    output logic       hirc_en,
    output logic       hxt_en,
    output logic       lirc_en,
    output logic       lxt_en,
    output logic       sys_clk,
    output logic       cpu_clk,
    output logic [1:0] mode
);

    localparam int               SEL_W    = CSEL_W;
    localparam int               N_SRC    = 2;
    localparam logic [SEL_W-1:0] CODE_LOW = '1;

    logic [SEL_W-1:0] csel;
    logic             hi_xt, lo_xt;
    pwr_mode_e        mode_q;
    osc_en_t          osc_en;

    logic [N_SRC-1:0] src_a, src_b, src_sel, src_out;
    logic             hi_clk, lo_clk, div_clk, hp_clk;

    clkctl_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .halt    (halt),
        .wake    (wake),
        .rd_data (rd_data),
        .csel    (csel),
        .hi_xt   (hi_xt),
        .lo_xt   (lo_xt),
        .mode    (mode_q),
        .osc_en  (osc_en)
    );

    // index 0: fast source pair, index 1: slow source pair
    assign src_a   = {lirc_clk, hirc_clk};
    assign src_b   = {lxt_clk,  hxt_clk};
    assign src_sel = {lo_xt,    hi_xt};

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        clk_gmux u_mux (
            .rst   (rst),
            .clk_a (src_a[g]),
            .clk_b (src_b[g]),
            .sel   (src_sel[g]),
            .clk_o (src_out[g])
        );
    end

    assign hi_clk = src_out[0];
    assign lo_clk = src_out[1];

    clk_pow2_div #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_div (
        .rst   (rst),
        .clk_i (hi_clk),
        .csel  (csel),
        .clk_o (div_clk)
    );

    clk_gmux u_hipath (
        .rst   (rst),
        .clk_a (hi_clk),
        .clk_b (div_clk),
        .sel   (csel != '0),
        .clk_o (hp_clk)
    );

    clk_gmux u_final (
        .rst   (rst),
        .clk_a (hp_clk),
        .clk_b (lo_clk),
        .sel   (csel == CODE_LOW),
        .clk_o (sys_clk)
    );

    clk_gate_sync u_gate (
        .rst   (rst),
        .clk_i (sys_clk),
        .en    (mode_q == MODE_RUN),
        .clk_o (cpu_clk)
    );

    assign hirc_en = osc_en.hirc;
    assign hxt_en  = osc_en.hxt;
    assign lirc_en = osc_en.lirc;
    assign lxt_en  = osc_en.lxt;
    assign mode    = mode_q;

endmodule

// File: tb/sysclk_idle_ctrl_test.sv
`timescale 1ns/1ps
module sysclk_idle_ctrl_test;

    logic       clk = 1'b0, rst = 1'b1;
    logic       wr_en = 1'b0, halt = 1'b0, wake = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       hirc_clk = 1'b0, hxt_clk = 1'b0, lirc_clk = 1'b0, lxt_clk = 1'b0;
    logic       hirc_en, hxt_en, lirc_en, lxt_en, sys_clk, cpu_clk;
    logic [1:0] mode;

    int  n_checks = 0, n_fail = 0;
    bit  finished = 1'b0;

    sysclk_idle_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .halt(halt), .wake(wake),
        .hirc_clk(hirc_clk), .hxt_clk(hxt_clk), .lirc_clk(lirc_clk), .lxt_clk(lxt_clk),
        .hirc_en(hirc_en), .hxt_en(hxt_en), .lirc_en(lirc_en), .lxt_en(lxt_en),
        .sys_clk(sys_clk), .cpu_clk(cpu_clk), .mode(mode)
    );

    always #2 clk = ~clk;
    initial begin #0.25; forever #5  hirc_clk = ~hirc_clk; end
    initial begin #0.25; forever #7  hxt_clk  = ~hxt_clk;  end
    initial begin #0.25; forever #50 lirc_clk = ~lirc_clk; end
    initial begin #0.25; forever #80 lxt_clk  = ~lxt_clk;  end

    // phase-width monitors for R10
    bit  mon_on = 1'b0;
    real min_hi = 1.0e9, min_lo = 1.0e9;
    real s_rise = -1.0, s_fall = -1.0, c_rise = -1.0, c_fall = -1.0;
    always @(posedge sys_clk) begin
        if (mon_on && s_fall >= 0.0 && ($realtime - s_fall) < min_lo) min_lo = $realtime - s_fall;
        s_rise = $realtime;
    end
    always @(negedge sys_clk) begin
        if (mon_on && s_rise >= 0.0 && ($realtime - s_rise) < min_hi) min_hi = $realtime - s_rise;
        s_fall = $realtime;
    end
    always @(posedge cpu_clk) begin
        if (mon_on && c_fall >= 0.0 && ($realtime - c_fall) < min_lo) min_lo = $realtime - c_fall;
        c_rise = $realtime;
    end
    always @(negedge cpu_clk) begin
        if (mon_on && c_rise >= 0.0 && ($realtime - c_rise) < min_hi) min_hi = $realtime - c_rise;
        c_fall = $realtime;
    end

    task automatic chk(input string req, input bit ok, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse(input bit do_halt, input bit do_wake);
        @(negedge clk); halt = do_halt; wake = do_wake;
        @(negedge clk); halt = 1'b0; wake = 1'b0;
    endtask

    task automatic get_period(input bit use_cpu, output int per);
        bit  prev, cur;
        int  edges;
        real t1;
        per = -1; edges = 0; t1 = 0.0;
        prev = use_cpu ? cpu_clk : sys_clk;
        for (int i = 0; i < 4000; i++) begin
            #1;
            cur = use_cpu ? cpu_clk : sys_clk;
            if (cur && !prev) begin
                edges++;
                if (edges == 1) t1 = $realtime;
                else begin per = int'($realtime - t1); break; end
            end
            prev = cur;
        end
    endtask

    task automatic count_rises(input bit use_cpu, input int ns, output int n);
        bit prev, cur;
        n = 0;
        prev = use_cpu ? cpu_clk : sys_clk;
        for (int i = 0; i < ns; i++) begin
            #1;
            cur = use_cpu ? cpu_clk : sys_clk;
            if (cur && !prev) n++;
            prev = cur;
        end
    endtask

    task automatic chk_en(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {hirc_en, hxt_en, lirc_en, lxt_en};
        chk(req, act == exp, "osc enables {hirc,hxt,lirc,lxt}", int'(act), int'(exp));
    endtask

    typedef struct packed {
        logic [7:0] wval;
        logic [15:0] per;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 16'd10},  '{8'h20, 16'd20},  '{8'h40, 16'd40},  '{8'h60, 16'd80},
        '{8'h80, 16'd160}, '{8'hA0, 16'd320}, '{8'hC0, 16'd640}, '{8'hE0, 16'd100},
        '{8'h08, 16'd14},  '{8'h68, 16'd112}, '{8'hE4, 16'd160}, '{8'hEC, 16'd160},
        '{8'h0C, 16'd14},  '{8'h13, 16'd10}
    };

    initial begin
        #700000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int p, n;
        logic [7:0] expr;
        repeat (20) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", rd_data == 8'h00, "rd_data", int'(rd_data), 0);
        chk("R1", mode == 2'd0, "mode", int'(mode), 0);
        chk_en("R1", 4'b1010);
        #300;
        mon_on = 1'b1;

        // R2 R3 R4 R5 R10: vector walk over codes and sources
        for (int v = 0; v < NV; v++) begin
            write_reg(VECS[v].wval);
            expr = VECS[v].wval & 8'hEF;
            chk("R2", rd_data == expr, "readback", int'(rd_data), int'(expr));
            chk_en("R4 R5", {~expr[3], expr[3], ~expr[2], expr[2]});
            #3000;
            get_period(1'b0, p);
            chk("R3", p == int'(VECS[v].per), "sys_clk period ns", p, int'(VECS[v].per));
            get_period(1'b1, p);
            chk("R3", p == int'(VECS[v].per), "cpu_clk period ns", p, int'(VECS[v].per));
        end
        chk("R10", min_hi > 4.99, "min high phase ns", int'(min_hi), 5);
        chk("R10", min_lo > 4.99, "min low phase ns", int'(min_lo), 5);

        // R6: IDLE1
        write_reg(8'h03);
        #400;
        pulse(1'b1, 1'b0);
        chk("R6", mode == 2'd1, "mode", int'(mode), 1);
        chk_en("R6", 4'b1010);
        #50;
        count_rises(1'b1, 500, n);
        chk("R6", n == 0, "cpu_clk rises while idle", n, 0);
        get_period(1'b0, p);
        chk("R6", p == 10, "sys_clk period in idle", p, 10);
        // R11: halt while halted ignored
        pulse(1'b1, 1'b0);
        chk("R11", mode == 2'd1, "mode after second halt", int'(mode), 1);
        // R9: wake
        pulse(1'b0, 1'b1);
        chk("R9", mode == 2'd0, "mode after wake", int'(mode), 0);
        count_rises(1'b1, 25, n);
        chk("R9", n >= 1, "cpu_clk rises soon after wake", n, 1);
        get_period(1'b1, p);
        chk("R9", p == 10, "cpu_clk period after wake", p, 10);

        // R7: IDLE2, internal then external fast source
        write_reg(8'h02);
        #100;
        pulse(1'b1, 1'b0);
        chk("R7", mode == 2'd2, "mode", int'(mode), 2);
        chk_en("R7", 4'b1000);
        #50;
        count_rises(1'b1, 300, n);
        chk("R7", n == 0, "cpu_clk rises while idle", n, 0);
        pulse(1'b0, 1'b1);
        write_reg(8'h0E);
        #400;
        pulse(1'b1, 1'b0);
        chk("R7", mode == 2'd2, "mode with crystals", int'(mode), 2);
        chk_en("R7", 4'b0100);
        pulse(1'b0, 1'b1);

        // R8: STOP
        write_reg(8'h01);
        #400;
        pulse(1'b1, 1'b0);
        chk("R8", mode == 2'd3, "mode", int'(mode), 3);
        chk_en("R8", 4'b0000);
        #50;
        count_rises(1'b1, 300, n);
        chk("R8", n == 0, "cpu_clk rises while stopped", n, 0);
        // R11: halt and wake together in a halted state -> run
        pulse(1'b1, 1'b1);
        chk("R11", mode == 2'd0, "mode after halt+wake", int'(mode), 0);

        // R11: wake in run ignored, halt+wake in run stays run
        write_reg(8'h03);
        pulse(1'b0, 1'b1);
        chk("R11", mode == 2'd0, "mode after wake in run", int'(mode), 0);
        chk("R11", rd_data == 8'h03, "rd_data after wake in run", int'(rd_data), 3);
        pulse(1'b1, 1'b1);
        chk("R11", mode == 2'd0, "mode after halt+wake in run", int'(mode), 0);

        // R1: reset again from a loaded state
        write_reg(8'hFF);
        pulse(1'b1, 1'b0);
        @(negedge clk); rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", rd_data == 8'h00, "rd_data after re-reset", int'(rd_data), 0);
        chk("R1", mode == 2'd0, "mode after re-reset", int'(mode), 0);
        chk_en("R1", 4'b1010);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule